// File: doc/BRIEF.md
# Three-Mode PWM Counter Channel

This block is a single timer counter joined to one compare channel. It produces a pulse-width-modulated reference level. Three counting schemes are available. In the first, the counter ramps up from zero to a reload limit. In the second, it ramps down from the limit to zero. In the third, it climbs to the limit and falls back to zero, which gives a symmetric waveform. In every scheme the reference is high while the counter lies on the "active" side of the compare threshold. Out-of-range thresholds saturate the output at a fixed level, and the saturation rules depend on the scheme.

Software programs the block through a narrow write port. The port selects one of three targets: the reload limit, the compare threshold, or a control word holding a direction bit and a two-bit symmetric-mode select. The limit and the threshold are staged in holding registers. They take effect only at the period boundary, so a new setting never produces a torn period. At the boundary the block raises a one-cycle update pulse. On a compare match it raises a one-cycle match pulse. In symmetric mode the match pulse can be restricted to the rising half, the falling half, or both halves.

Top module: `tri_mode_pwm`

## Requirements
- R1: `rst` is synchronous and active high. On the edge where it is sampled high, the counter and the hardware direction go to 0, and `pwm_ref`, `cmp_flag` and `upd_evt` go to 0. Writes are still accepted while `rst` is high, and during reset the working limit and threshold copy their staged values on every edge.
- R2: A write with `wr_en` high stores `wr_data` according to `wr_sel`. The value 0 selects the reload limit, 1 the compare threshold, and 2 the control word, where bit 0 is the edge-mode direction (0 up, 1 down) and bits 2:1 are the symmetric-mode select. A write with `wr_sel` = 3 changes nothing. In edge modes `dir_out` shows the stored direction bit.
- R3: With select 00 and direction 0, the counter steps 0, 1, ..., limit and then returns to 0. The period is limit+1 cycles, and `upd_evt` is high for one cycle in the cycle the counter is back at 0.
- R4: With select 00 and direction 1, the counter steps limit, ..., 0 and then reloads the limit. The period is limit+1 cycles with one `upd_evt` pulse per period.
- R5: In up mode, `pwm_ref` in a cycle equals (counter < threshold) evaluated one cycle earlier. A threshold of 0 keeps it low. It is high for exactly `threshold` cycles per period.
- R6: In down mode, `pwm_ref` equals (counter <= threshold) evaluated one cycle earlier. It is high for threshold+1 cycles per period and never stays low for a whole period.
- R7: If the threshold exceeds the limit, `pwm_ref` stays high in every mode.
- R8: Any nonzero select runs the counter 0 up to the limit and back down to 1, so the period is 2×limit cycles with one `upd_evt` pulse, issued when the counter leaves 0. Each endpoint lasts one cycle. `pwm_ref` is high 2×threshold−1 cycles per period for a threshold of 1..limit, and 0 cycles for a threshold of 0. All three nonzero selects give the same waveform.
- R9: In symmetric mode the hardware drives the direction. `dir_out` is 1 while counting down (from limit−1 to 0), which is `limit` cycles per period, and it changes only after an endpoint. A control write's direction bit has no effect while its select is nonzero.
- R10: `cmp_flag` pulses for one cycle, one cycle after the counter equals the threshold. In edge modes every match counts. In symmetric mode, select 01 counts only matches while counting down, 10 only matches while counting up, and 11 counts both. The top endpoint counts as up and the bottom endpoint counts as down.
- R11: The limit and threshold in use change only together with an `upd_evt` pulse. The period in progress keeps its old length and threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 limit, 1 threshold, 2 control, 3 none |
| wr_data | input | DATA_W | Write value |
| pwm_ref | output | 1 | Registered PWM reference level |
| cmp_flag | output | 1 | One-cycle compare-match pulse |
| upd_evt | output | 1 | One-cycle period-boundary pulse |
| dir_out | output | 1 | Current counting direction (1 = down) |

## Verification
A counter that strays from its expected path shows up at the ports within one period. The number of high cycles of `pwm_ref` over a window of one period length drifts, and the spacing between `upd_evt` pulses no longer matches limit+1 or 2×limit. A wrong hardware direction changes both how long `dir_out` stays high and which halves produce `cmp_flag`, again within one period. Errors in the staging registers appear at the first boundary after a write, because the interval between pulses either shortens too early or never changes.

// File: rtl/tri_mode_pwm_pkg.sv
package tri_mode_pwm_pkg;

   typedef enum logic [1:0] {
      REG_RELOAD  = 2'd0,
      REG_COMPARE = 2'd1,
      REG_CTRL    = 2'd2,
      REG_NONE    = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      CSEL_EDGE = 2'd0,
      CSEL_DOWN = 2'd1,
      CSEL_UP   = 2'd2,
      CSEL_BOTH = 2'd3
   } csel_e;

   localparam int CTRL_DIR_BIT = 0;
   localparam int CTRL_SEL_LSB = 1;
   localparam int CTRL_W       = 3;

endpackage

// File: rtl/tri_mode_pwm_regs.sv
module tri_mode_pwm_regs
   import tri_mode_pwm_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              load,
   output logic [DATA_W-1:0] arr_shadow,
   output logic [DATA_W-1:0] arr_act,
   output logic [DATA_W-1:0] ccr_act,
   output csel_e             csel,
   output logic              sw_dir
);

   logic [DATA_W-1:0] ccr_shadow;
   reg_sel_e          sel;
   logic [1:0]        sel_field;

   assign sel       = reg_sel_e'(wr_sel);
   assign sel_field = wr_data[CTRL_SEL_LSB +: 2];

   // staging registers and control word
   always_ff @(posedge clk) begin
      if (wr_en) begin
         case (sel)
            REG_RELOAD:  arr_shadow <= wr_data;
            REG_COMPARE: ccr_shadow <= wr_data;
            REG_CTRL: begin
               csel <= csel_e'(sel_field);
               if (sel_field == 2'b00)
                  sw_dir <= wr_data[CTRL_DIR_BIT];
            end
            default: ;
         endcase
      end
   end

   // working copies follow the staged values at a boundary or in reset
   always_ff @(posedge clk) begin
      if (rst || load) begin
         arr_act <= arr_shadow;
         ccr_act <= ccr_shadow;
      end
   end

endmodule

// File: rtl/tri_mode_pwm_counter.sv
module tri_mode_pwm_counter
   import tri_mode_pwm_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter bit CENTER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  csel_e             csel,
   input  logic              sw_dir,
   input  logic [DATA_W-1:0] arr_act,
   input  logic [DATA_W-1:0] arr_shadow,
   output logic [DATA_W-1:0] cnt,
   output logic              hw_dir,
   output logic              center_on,
   output logic              going_down,
   output logic              wrap
);

   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   logic [DATA_W-1:0] cnt_e;
   logic [DATA_W-1:0] cnt_c;
   logic              wrap_e;
   logic              wrap_c;
   logic              dir_c;

   // edge-aligned stepping, either direction
   always_comb begin
      wrap_e = sw_dir ? (cnt == '0) : (cnt >= arr_act);
      if (!sw_dir)
         cnt_e = wrap_e ? '0 : cnt + ONE;
      else
         cnt_e = wrap_e ? arr_shadow : cnt - ONE;
   end

   generate
      if (CENTER_EN) begin : g_center
         assign center_on = (csel != CSEL_EDGE);
         always_comb begin
            cnt_c  = cnt;
            dir_c  = hw_dir;
            wrap_c = 1'b0;
            if (!hw_dir) begin
               if (cnt >= arr_act) begin
                  dir_c = 1'b1;
                  cnt_c = (arr_act == '0) ? '0 : arr_act - ONE;
               end else begin
                  cnt_c = cnt + ONE;
               end
            end else begin
               if (cnt == '0) begin
                  dir_c  = 1'b0;
                  wrap_c = 1'b1;
                  cnt_c  = (arr_shadow == '0) ? '0 : ONE;
               end else begin
                  cnt_c = cnt - ONE;
               end
            end
         end
      end else begin : g_edge_only
         assign center_on = 1'b0;
         assign cnt_c     = '0;
         assign dir_c     = 1'b0;
         assign wrap_c    = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt    <= '0;
         hw_dir <= 1'b0;
      end else if (center_on) begin
         cnt    <= cnt_c;
         hw_dir <= dir_c;
      end else begin
         cnt    <= cnt_e;
         hw_dir <= 1'b0;
      end
   end

   assign wrap       = center_on ? wrap_c : wrap_e;
   assign going_down = center_on ? hw_dir : sw_dir;

endmodule

// File: rtl/tri_mode_pwm_out.sv
module tri_mode_pwm_out #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] cnt,
   input  logic [DATA_W-1:0] ccr_act,
   input  logic              center_on,
   input  logic              going_down,
   input  logic              flag_up_en,
   input  logic              flag_dn_en,
   input  logic              wrap,
   output logic              pwm_ref,
   output logic              cmp_flag,
   output logic              upd_evt
);

   logic level;
   logic match;
   logic allow;

   always_comb begin
      if (!center_on && going_down)
         level = (cnt <= ccr_act);
      else
         level = (cnt < ccr_act);
      match = (cnt == ccr_act);
      allow = !center_on || (going_down ? flag_dn_en : flag_up_en);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pwm_ref  <= 1'b0;
         cmp_flag <= 1'b0;
         upd_evt  <= 1'b0;
      end else begin
         pwm_ref  <= level;
         cmp_flag <= match && allow;
         upd_evt  <= wrap;
      end
   end

endmodule

// File: rtl/tri_mode_pwm.sv
module tri_mode_pwm
   import tri_mode_pwm_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter bit CENTER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              pwm_ref,
   output logic              cmp_flag,
   output logic              upd_evt,
   output logic              dir_out
);

   generate
      if (DATA_W < CTRL_W) begin : g_bad_width
         $error("tri_mode_pwm: DATA_W must hold the control word");
      end
   endgenerate

   logic [DATA_W-1:0] arr_shadow;
   logic [DATA_W-1:0] arr_act;
   logic [DATA_W-1:0] ccr_act;
   logic [DATA_W-1:0] cnt;
   csel_e             csel;
   logic              sw_dir;
   logic              hw_dir;
   logic              center_on;
   logic              going_down;
   logic              wrap;

   tri_mode_pwm_regs #(.DATA_W(DATA_W)) u_regs (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (wr_en),
      .wr_sel     (wr_sel),
      .wr_data    (wr_data),
      .load       (wrap),
      .arr_shadow (arr_shadow),
      .arr_act    (arr_act),
      .ccr_act    (ccr_act),
      .csel       (csel),
      .sw_dir     (sw_dir)
   );

   tri_mode_pwm_counter #(.DATA_W(DATA_W), .CENTER_EN(CENTER_EN)) u_counter (
      .clk        (clk),
      .rst        (rst),
      .csel       (csel),
      .sw_dir     (sw_dir),
      .arr_act    (arr_act),
      .arr_shadow (arr_shadow),
      .cnt        (cnt),
      .hw_dir     (hw_dir),
      .center_on  (center_on),
      .going_down (going_down),
      .wrap       (wrap)
   );

   tri_mode_pwm_out #(.DATA_W(DATA_W)) u_out (
      .clk        (clk),
      .rst        (rst),
      .cnt        (cnt),
      .ccr_act    (ccr_act),
      .center_on  (center_on),
      .going_down (going_down),
      .flag_up_en (csel[1]),
      .flag_dn_en (csel[0]),
      .wrap       (wrap),
      .pwm_ref    (pwm_ref),
      .cmp_flag   (cmp_flag),
      .upd_evt    (upd_evt)
   );

   assign dir_out = going_down;

endmodule

// File: rtl/tri_mode_pwm_chk.sv
module tri_mode_pwm_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic [DATA_W-1:0] cnt,
   input logic [DATA_W-1:0] arr_act,
   input logic [DATA_W-1:0] ccr_act,
   input logic              center_on,
   input logic              going_down,
   input logic              pwm_ref,
   input logic              cmp_flag,
   input logic              upd_evt,
   input logic              dir_out
);

   logic up_edge;
   logic down_edge;
   assign up_edge   = !center_on && !going_down;
   assign down_edge = !center_on && going_down;

   AST_RST_CLEARS: assert property (@(posedge clk)
      rst |=> (!pwm_ref && !cmp_flag && !upd_evt && cnt == '0)); // R1

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      cnt <= arr_act); // R3

   AST_UPD_AT_END: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && upd_evt) |-> $past(cnt == '0 || cnt == arr_act)); // R4

   AST_UP_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(up_edge && ccr_act == '0)) |-> !pwm_ref); // R5

   AST_DOWN_NEVER_EMPTY: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(down_edge && cnt == '0)) |-> pwm_ref); // R6

   AST_OVER_RANGE_HIGH: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(ccr_act > arr_act)) |-> pwm_ref); // R7

   AST_DIR_AT_ENDPOINTS: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && center_on && $past(center_on) &&
       $past(cnt != '0 && cnt != arr_act)) |-> $stable(dir_out)); // R9

   AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && cmp_flag) |-> $past(cnt == ccr_act)); // R10

   AST_STAGED_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !upd_evt) |-> ($stable(arr_act) && $stable(ccr_act))); // R11

endmodule

bind tri_mode_pwm tri_mode_pwm_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .cnt        (cnt),
   .arr_act    (arr_act),
   .ccr_act    (ccr_act),
   .center_on  (center_on),
   .going_down (going_down),
   .pwm_ref    (pwm_ref),
   .cmp_flag   (cmp_flag),
   .upd_evt    (upd_evt),
   .dir_out    (dir_out)
);

// File: tb/tri_mode_pwm_bench.sv
module tri_mode_pwm_bench;

   localparam int W  = 8;
   localparam int NV = 16;
   // columns: limit, threshold, control, period, high cycles, flags, dir cycles
   localparam int VEC [NV][7] = '{
      '{8, 3, 0, 9, 3, 1, 0},
      '{8, 0, 0, 9, 0, 1, 0},
      '{8, 9, 0, 9, 9, 0, 0},
      '{8, 8, 0, 9, 8, 1, 0},
      '{8, 3, 1, 9, 4, 1, 9},
      '{8, 0, 1, 9, 1, 1, 9},
      '{8, 12, 1, 9, 9, 0, 9},
      '{4, 2, 2, 8, 3, 1, 4},
      '{4, 2, 4, 8, 3, 1, 4},
      '{4, 2, 6, 8, 3, 2, 4},
      '{4, 0, 6, 8, 0, 1, 4},
      '{4, 0, 2, 8, 0, 1, 4},
      '{4, 0, 4, 8, 0, 0, 4},
      '{4, 4, 2, 8, 7, 0, 4},
      '{4, 4, 4, 8, 7, 1, 4},
      '{4, 5, 7, 8, 8, 0, 4}
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_sel = 2'd0;
   logic [W-1:0] wr_data = '0;
   logic         pwm_ref;
   logic         cmp_flag;
   logic         upd_evt;
   logic         dir_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   tri_mode_pwm #(.DATA_W(W)) u_tri_mode_pwm (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .pwm_ref  (pwm_ref),
      .cmp_flag (cmp_flag),
      .upd_evt  (upd_evt),
      .dir_out  (dir_out)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] s, input int d);
      wr_en   = 1'b1;
      wr_sel  = s;
      wr_data = W'(d);
      step();
      wr_en   = 1'b0;
   endtask

   task automatic setup(input int lim, input int thr, input int ctl);
      rst = 1'b1;
      wr(2'd0, lim);
      wr(2'd1, thr);
      wr(2'd2, ctl);
      step();
      rst = 1'b0;
   endtask

   task automatic measure(input int p, output int hi, output int fl, output int dr, output int up);
      hi = 0; fl = 0; dr = 0; up = 0;
      for (int i = 0; i < p; i++) begin
         step();
         hi += int'(pwm_ref);
         fl += int'(cmp_flag);
         dr += int'(dir_out);
         up += int'(upd_evt);
      end
   endtask

   task automatic wait_upd();
      for (int i = 0; i < 100; i++) begin
         if (upd_evt) break;
         step();
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int hi, fl, dr, up, n;
      string mreq, ureq;

      // R1: outputs cleared while reset is held
      step(); step();
      check("R1", "pwm_ref in reset", int'(pwm_ref), 0);
      check("R1", "cmp_flag in reset", int'(cmp_flag), 0);
      check("R1", "upd_evt in reset", int'(upd_evt), 0);

      // vector table: per-period counts in steady state
      for (int v = 0; v < NV; v++) begin
         setup(VEC[v][0], VEC[v][1], VEC[v][2]);
         repeat (3 * VEC[v][3]) step();
         measure(VEC[v][3], hi, fl, dr, up);
         if (VEC[v][2] >= 2) begin
            mreq = "R8"; ureq = "R8";
         end else if (VEC[v][2] == 1) begin
            mreq = "R6"; ureq = "R4";
         end else begin
            mreq = "R5"; ureq = "R3";
         end
         if (VEC[v][1] > VEC[v][0]) mreq = "R7";
         check(mreq, $sformatf("vec %0d high cycles", v), hi, VEC[v][4]);
         check("R10", $sformatf("vec %0d match pulses", v), fl, VEC[v][5]);
         check((VEC[v][2] >= 2) ? "R9" : "R2", $sformatf("vec %0d dir cycles", v), dr, VEC[v][6]);
         check(ureq, $sformatf("vec %0d update pulses", v), up, 1);
      end

      // R5: phase of the up-mode output relative to the boundary
      setup(8, 3, 0);
      wait_upd();
      check("R5", "ref at boundary", int'(pwm_ref), 0);
      for (int k = 0; k < 4; k++) begin
         step();
         check("R5", $sformatf("ref %0d after boundary", k + 1), int'(pwm_ref), (k < 3) ? 1 : 0);
      end

      // R2: select 3 writes nothing
      repeat (12) step();
      wr(2'd3, 0);
      repeat (18) step();
      measure(9, hi, fl, dr, up);
      check("R2", "high cycles after sel 3 write", hi, 3);
      check("R2", "update pulses after sel 3 write", up, 1);

      // R11: staged values take effect only at the boundary
      setup(7, 2, 0);
      repeat (4) step();
      wait_upd();
      wr(2'd0, 3);
      wr(2'd1, 1);
      n = 2;
      while (!upd_evt && n < 50) begin
         step();
         n++;
      end
      check("R11", "period after staging write", n, 8);
      hi = 0; n = 0;
      do begin
         hi += int'(pwm_ref);
         step();
         n++;
      end while (!upd_evt && n < 50);
      check("R11", "new period length", n, 4);
      check("R11", "new period high cycles", hi, 1);

      // R7 then R1: reset mid-run clears a held-high output
      setup(8, 9, 0);
      repeat (10) step();
      check("R7", "held high before reset", int'(pwm_ref), 1);
      rst = 1'b1;
      step();
      check("R1", "pwm_ref after mid-run reset", int'(pwm_ref), 0);
      check("R1", "cmp_flag after mid-run reset", int'(cmp_flag), 0);
      check("R1", "upd_evt after mid-run reset", int'(upd_evt), 0);
      rst = 1'b0;

      // R9: direction bit written mid-run in symmetric mode is ignored
      setup(4, 2, 6);
      repeat (13) step();
      wr(2'd2, 7);
      repeat (16) step();
      measure(8, hi, fl, dr, up);
      check("R9", "dir cycles after dir write", dr, 4);
      check("R9", "high cycles after dir write", hi, 3);
      check("R10", "match pulses after dir write", fl, 2);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule